// File: doc/BRIEF.md
# Multi-path PCM capture FIFO with DMA request

This block gathers decimated PCM samples from up to four stereo capture paths and stores them in one shared receive FIFO of 32-bit words. A host bus master drains the FIFO through a 32-bit read port, paced by a DMA request output. Software programs the active channel count (2, 4, 6 or 8) and the sample width through a small register interface. The path enables follow from the channel count: path 0 is always on, and each further pair of channels adds the next path.

A capture frame arrives on one `frame_valid` strobe carrying the left and right sample of every path. The block left-justifies each sample to the programmed width and writes the enabled paths into the FIFO one word per cycle, path 0 first and left before right. A frame therefore occupies consecutive FIFO entries. The DMA request rises once eight words per active channel are waiting. Capture is armed and halted through a control register, and the same write can also flush the FIFO.

Top module: `pdm_rx_fifo`

## Requirements
- R1: After reset the FIFO is empty, `dma_req` is 0, both status flags are 0, capture and DMA are disabled, and the format register (address 1) reads 0x112. That value is channel count 2 in bits [3:0], width code 1 in bits [6:4] and path enables 0001 in bits [11:8].
- R2: Writing a channel count of 2, 4, 6 or 8 to format bits [3:0] sets the path enables (format readback bits [11:8]) to 0001, 0011, 0111 or 1111 respectively.
- R3: A format write is dropped as a whole, leaving count, width and path enables unchanged, if its channel count is not 2, 4, 6 or 8 or its width code (bits [6:4]) is above 4.
- R4: An accepted frame writes exactly as many words as the channel count, in the order path 0 left, path 0 right, path 1 left, and so on. Disabled paths are skipped.
- R5: Each stored word is the low W bits of the input sample placed in bits [31:32-W], with the lower bits zero. W is 8, 16, 20, 24 or 32 for width codes 0 to 4.
- R6: `dma_req` is 1 exactly when the DMA enable (control bit 1) is set and the fill level is at least 8 times the channel count.
- R7: A frame presented while capture is stopped (control bit 0 clear) writes nothing.
- R8: A word pushed into a full FIFO is dropped and sets the sticky overflow flag (status bit 0). Writing 1 to that bit clears it.
- R9: A read from an empty FIFO returns 0, leaves the level at 0 and sets the sticky underflow flag (status bit 1). Writing 1 to that bit clears it.
- R10: Writing control bit 2 as 1 empties the FIFO and aborts any frame still being written, so the level reads 0 on the following cycle.
- R11: A frame presented while the previous frame is still being written is dropped whole and sets the overflow flag.
- R12: The status register (address 2) shows the fill level in bits [14:8], and popped words leave in the order they were written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register address: 0 control, 1 format, 2 status |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for `cfg_addr` (combinational) |
| frame_valid | input | 1 | One capture frame is present on the sample inputs |
| smp_left | input | 128 | Left samples, path p in bits [32p+31:32p], right-justified |
| smp_right | input | 128 | Right samples, same layout as `smp_left` |
| fifo_rd | input | 1 | Pop one word from the FIFO |
| fifo_rdata | output | 32 | Head-of-FIFO word, 0 when empty |
| dma_req | output | 1 | DMA read request |

## Verification
The bench targets the watermark edge. At two channels, 14 stored words must keep `dma_req` low and 16 must raise it. A design that compared against a fixed burst size, or that ignored the DMA enable, raises the request early or while disabled. The bench also fills the FIFO exactly to 64 words and then offers one more frame. A design with an off-by-one full test would store a wrapped word or lose a valid one, and the drained sequence would not match. A second frame sent back to back with the first must vanish: a design that queued it or merged it into the first would show an extra frame or swapped words. An invalid format write must not disturb the current setup: a design that validated the fields one at a time would pick up the width alone. The bench also covers a read from an empty FIFO and a flush while a frame is half written. A design that let the flush lose to a concurrent push would show a level of one after the flush.

// File: rtl/pdm_rx_fifo.sv
module pdm_rx_fifo #(
  parameter int NUM_PATHS   = 4,
  parameter int DEPTH       = 64,
  parameter int BURST_WORDS = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cfg_we,
  input  logic [1:0]                cfg_addr,
  input  logic [31:0]               cfg_wdata,
  output logic [31:0]               cfg_rdata,
  input  logic                      frame_valid,
  input  logic [NUM_PATHS*32-1:0]   smp_left,
  input  logic [NUM_PATHS*32-1:0]   smp_right,
  input  logic                      fifo_rd,
  output logic [31:0]               fifo_rdata,
  output logic                      dma_req
);
  localparam int NCH_MAX = 2 * NUM_PATHS;
  localparam int AW      = $clog2(DEPTH);
  localparam int LW      = $clog2(DEPTH + 1);
  localparam int IW      = $clog2(NCH_MAX);

  logic              run_q, dma_en_q, ovf_q, unf_q, busy_q;
  logic [3:0]        nch_q;
  logic [2:0]        wcode_q;
  logic [IW-1:0]     idx_q;
  logic [AW-1:0]     wptr_q, rptr_q;
  logic [LW-1:0]     count_q;
  logic [31:0]       frame_q [NCH_MAX];
  logic [31:0]       mem_q   [DEPTH];
  logic [NUM_PATHS-1:0] path_en;

  for (genvar p = 0; p < NUM_PATHS; p++) begin : g_en
    assign path_en[p] = (int'(nch_q) > 2 * p);
  end

  function automatic logic [31:0] justify(input logic [31:0] s, input logic [2:0] c);
    case (c)
      3'd0:    justify = s << 24;
      3'd1:    justify = s << 16;
      3'd2:    justify = s << 12;
      3'd3:    justify = s << 8;
      default: justify = s;
    endcase
  endfunction

  wire wr_ctrl = cfg_we && (cfg_addr == 2'd0);
  wire wr_fmt  = cfg_we && (cfg_addr == 2'd1);
  wire wr_stat = cfg_we && (cfg_addr == 2'd2);
  wire clr     = wr_ctrl && cfg_wdata[2];
  wire fmt_ok  = !cfg_wdata[0] && (cfg_wdata[3:0] != 4'd0) &&
                 (int'(cfg_wdata[3:0]) <= NCH_MAX) && (cfg_wdata[6:4] <= 3'd4);

  wire full    = (int'(count_q) == DEPTH);
  wire empty   = (count_q == '0);
  wire push    = busy_q;
  wire do_push = push && !full && !clr;
  wire do_pop  = fifo_rd && !empty && !clr;
  wire accept  = frame_valid && run_q && !busy_q && !clr;
  wire f_drop  = frame_valid && run_q && busy_q && !clr;
  wire last    = (int'(idx_q) + 1 == int'(nch_q));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q    <= 1'b0;
      dma_en_q <= 1'b0;
      nch_q    <= 4'd2;
      wcode_q  <= 3'd1;
    end else begin
      if (wr_ctrl) begin
        run_q    <= cfg_wdata[0];
        dma_en_q <= cfg_wdata[1];
      end
      if (wr_fmt && fmt_ok) begin
        nch_q   <= cfg_wdata[3:0];
        wcode_q <= cfg_wdata[6:4];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
    end else if (clr) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
    end else if (accept) begin
      busy_q <= 1'b1;
      idx_q  <= '0;
    end else if (busy_q) begin
      busy_q <= !last;
      idx_q  <= last ? '0 : idx_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      for (int p = 0; p < NUM_PATHS; p++) begin
        frame_q[2*p]   <= justify(smp_left[p*32 +: 32], wcode_q);
        frame_q[2*p+1] <= justify(smp_right[p*32 +: 32], wcode_q);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr_q  <= '0;
      rptr_q  <= '0;
      count_q <= '0;
    end else if (clr) begin
      wptr_q  <= '0;
      rptr_q  <= '0;
      count_q <= '0;
    end else begin
      if (do_push) wptr_q <= (int'(wptr_q) == DEPTH - 1) ? '0 : wptr_q + 1'b1;
      if (do_pop)  rptr_q <= (int'(rptr_q) == DEPTH - 1) ? '0 : rptr_q + 1'b1;
      count_q <= count_q + LW'(do_push) - LW'(do_pop);
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem_q[wptr_q] <= frame_q[idx_q];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ovf_q <= 1'b0;
      unf_q <= 1'b0;
    end else begin
      if ((push && full && !clr) || f_drop) ovf_q <= 1'b1;
      else if (wr_stat && cfg_wdata[0])     ovf_q <= 1'b0;
      if (fifo_rd && empty && !clr)         unf_q <= 1'b1;
      else if (wr_stat && cfg_wdata[1])     unf_q <= 1'b0;
    end
  end

  assign fifo_rdata = empty ? 32'd0 : mem_q[rptr_q];
  assign dma_req    = dma_en_q && (32'(count_q) >= 32'(BURST_WORDS) * 32'(nch_q));

  always_comb begin
    cfg_rdata = '0;
    case (cfg_addr)
      2'd0: cfg_rdata[1:0] = {dma_en_q, run_q};
      2'd1: begin
        cfg_rdata[3:0]             = nch_q;
        cfg_rdata[6:4]             = wcode_q;
        cfg_rdata[8 +: NUM_PATHS]  = path_en;
      end
      2'd2: begin
        cfg_rdata[0]       = ovf_q;
        cfg_rdata[1]       = unf_q;
        cfg_rdata[8 +: LW] = count_q;
      end
      default: cfg_rdata = '0;
    endcase
  end

  // R2
  path_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot({1'b0, path_en} + 1'b1));

  // R6
  dma_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |-> (dma_en_q && !empty));

  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !clr) |=> (ovf_q && full));

  // R9
  empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_rd && empty && !clr) |=> unf_q);

  // R10
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (empty && !busy_q));

  // R12
  level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(count_q) <= DEPTH);

  // R11
  busy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    f_drop |=> ovf_q);
endmodule

// File: tb/pdm_rx_fifo_tb_top.sv
module pdm_rx_fifo_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 4;
  localparam int DEPTH = 64;

  logic clk = 0, rst_n = 0, cfg_we = 0, frame_valid = 0, fifo_rd = 0;
  logic [1:0] cfg_addr = 0;
  logic [31:0] cfg_wdata = 0, cfg_rdata, fifo_rdata;
  logic [NP*32-1:0] smp_left = 0, smp_right = 0;
  logic dma_req;

  int n_chk = 0, n_bad = 0;
  int nch_m = 2, wc_m = 1;
  logic [31:0] exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  pdm_rx_fifo dut_i (.clk, .rst_n, .cfg_we, .cfg_addr, .cfg_wdata, .cfg_rdata,
    .frame_valid, .smp_left, .smp_right, .fifo_rd, .fifo_rdata, .dma_req);

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); cfg_addr = a; #1 d = cfg_rdata;
  endtask

  task automatic set_fmt(input int n, input int w);
    wr(2'd1, 32'((w << 4) | n)); nch_m = n; wc_m = w;
  endtask

  function automatic logic [31:0] just(input logic [31:0] s, input int w);
    case (w) 0: return s << 24; 1: return s << 16; 2: return s << 12; 3: return s << 8; default: return s; endcase
  endfunction

  function automatic logic [31:0] lval(input logic [31:0] b, input int p); return b ^ (32'h1111_1111 * 32'(2*p+1)); endfunction
  function automatic logic [31:0] rval(input logic [31:0] b, input int p); return b ^ (32'h1111_1111 * 32'(2*p+2)); endfunction

  task automatic load(input logic [31:0] b);
    for (int p = 0; p < NP; p++) begin
      smp_left[p*32 +: 32] = lval(b, p);
      smp_right[p*32 +: 32] = rval(b, p);
    end
  endtask

  // driver: presents a frame and pushes expected words into the scoreboard
  task automatic send_frame(input logic [31:0] b, input bit acc);
    @(negedge clk); load(b); frame_valid = 1;
    if (acc)
      for (int p = 0; p < nch_m / 2; p++) begin
        if (exp_q.size() < DEPTH) exp_q.push_back(just(lval(b, p), wc_m));
        if (exp_q.size() < DEPTH) exp_q.push_back(just(rval(b, p), wc_m));
      end
    @(negedge clk); frame_valid = 0;
    repeat (nch_m + 1) @(negedge clk);
  endtask

  // monitor: pops design output and compares with the scoreboard
  task automatic drain(input string tag);
    logic [31:0] e, v;
    while (exp_q.size() > 0) begin
      @(negedge clk); fifo_rd = 0; #1;
      e = exp_q.pop_front();
      chk(fifo_rdata, e, tag);
      fifo_rd = 1;
    end
    @(negedge clk); fifo_rd = 0;
    rd(2'd2, v); chk(32'((v >> 8) & 32'h7f), 0, {tag, " level after drain"});
  endtask

  logic [31:0] v;

  initial begin
    repeat (3) @(negedge clk); rst_n = 1;
    // R1
    rd(2'd1, v); chk(v, 32'h112, "R1 format reset");
    rd(2'd2, v); chk(v, 0, "R1 status reset");
    rd(2'd0, v); chk(v, 0, "R1 control reset");
    chk(32'(dma_req), 0, "R1 dma_req reset");
    // R2
    set_fmt(4, 1); rd(2'd1, v); chk((v >> 8) & 15, 4'b0011, "R2 count 4");
    set_fmt(6, 1); rd(2'd1, v); chk((v >> 8) & 15, 4'b0111, "R2 count 6");
    set_fmt(8, 1); rd(2'd1, v); chk((v >> 8) & 15, 4'b1111, "R2 count 8");
    set_fmt(2, 1); rd(2'd1, v); chk((v >> 8) & 15, 4'b0001, "R2 count 2");
    // R3
    wr(2'd1, 32'h0000_0045); rd(2'd1, v); chk(v, 32'h112, "R3 odd count");
    wr(2'd1, 32'h0000_000a); rd(2'd1, v); chk(v, 32'h112, "R3 count 10");
    wr(2'd1, 32'h0000_0054); rd(2'd1, v); chk(v, 32'h112, "R3 width code 5");
    // R7
    send_frame(32'h0bad_0001, 0); rd(2'd2, v); chk(v, 0, "R7 stopped capture");
    // R4 R5
    wr(2'd0, 32'h1);
    set_fmt(8, 4); send_frame(32'h1234_5678, 1); drain("R4 order 8ch 32b");
    set_fmt(4, 0); send_frame(32'hcafe_00a5, 1); drain("R5 width 8");
    set_fmt(4, 1); send_frame(32'h0000_beef, 1); drain("R5 width 16");
    set_fmt(6, 2); send_frame(32'hfff9_abcd, 1); drain("R5 width 20");
    set_fmt(2, 3); send_frame(32'h0a12_3456, 1); send_frame(32'h0b65_4321, 1); drain("R5 width 24");
    // R6
    set_fmt(2, 4); wr(2'd0, 32'h3);
    for (int i = 0; i < 7; i++) send_frame(32'h6000_0000 + 32'(i), 1);
    chk(32'(dma_req), 0, "R6 level 14 below mark");
    send_frame(32'h6000_0007, 1);
    chk(32'(dma_req), 1, "R6 level 16 at mark");
    rd(2'd2, v); chk((v >> 8) & 32'h7f, 16, "R12 level 16");
    wr(2'd0, 32'h1); chk(32'(dma_req), 0, "R6 dma disabled");
    set_fmt(4, 4); chk(32'(dma_req), 0, "R6 count 4 raises mark");
    drain("R12 order");
    // R10
    set_fmt(8, 4);
    send_frame(32'h1010_0000, 1);
    @(negedge clk); load(32'h2020_0000); frame_valid = 1;
    @(negedge clk); frame_valid = 0;
    @(negedge clk); cfg_we = 1; cfg_addr = 0; cfg_wdata = 32'h5;
    @(negedge clk); cfg_we = 0;
    rd(2'd2, v); chk((v >> 8) & 32'h7f, 0, "R10 clear mid-frame");
    exp_q.delete();
    repeat (10) @(negedge clk);
    rd(2'd2, v); chk((v >> 8) & 32'h7f, 0, "R10 aborted frame stays out");
    // R8
    wr(2'd0, 32'h3);
    for (int i = 0; i < 8; i++) send_frame(32'h8000_0000 + 32'(i << 4), 1);
    chk(32'(dma_req), 1, "R6 full at mark 64");
    rd(2'd2, v); chk(v & 1, 0, "R8 no overflow at exact full");
    send_frame(32'h8fff_0000, 1);
    rd(2'd2, v); chk(v, 32'h4001, "R8 overflow set level 64");
    wr(2'd2, 32'h1); rd(2'd2, v); chk(v & 3, 0, "R8 w1c clears overflow");
    drain("R8 content after overflow");
    // R9
    @(negedge clk); #1 chk(fifo_rdata, 0, "R9 empty read data");
    fifo_rd = 1; @(negedge clk); fifo_rd = 0;
    rd(2'd2, v); chk(v, 32'h2, "R9 underflow set, level 0");
    wr(2'd2, 32'h2); rd(2'd2, v); chk(v, 0, "R9 w1c clears underflow");
    // R11
    set_fmt(4, 4);
    @(negedge clk); load(32'hb000_0001); frame_valid = 1;
    for (int p = 0; p < 2; p++) begin
      exp_q.push_back(lval(32'hb000_0001, p)); exp_q.push_back(rval(32'hb000_0001, p));
    end
    @(negedge clk); load(32'hb000_0002);
    @(negedge clk); frame_valid = 0;
    repeat (6) @(negedge clk);
    rd(2'd2, v); chk(v, 32'h0401, "R11 second frame dropped");
    drain("R11 first frame intact");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule